// File: doc/BRIEF.md
# Phase Comparator with Lock Detector

This block sits behind the two programmable dividers of a frequency synthesizer. It takes the divided reference pulse and the divided oscillator pulse and works out which of the two arrived first. From that it issues a three-state charge-pump command: drive high, drive low, or release. It also produces a pair of comparator outputs for an external pump, and one multiplexed status pin that carries either a lock flag or a monitor copy of one of the divided pulses. Phase error is measured in cycles of the oscillator clock that times the block. Both pulses are single-cycle strobes that are synchronous to that clock.

A polarity input swaps the sense of every comparator output, so the block can follow a loop filter and oscillator of either tuning slope. The lock flag drops on the first comparison whose error reaches the unlock threshold. It comes back only after a run of consecutive comparisons that all fall inside the lock threshold. A power-save input puts the comparator in its idle state, clears the lock history and forces the lock flag high. A separate enable can force the pump command to release regardless of the phase.

Top module: `phase_lock_det`

## Requirements
- R1: While reset is asserted and straight after it, cp_up_o, cp_dn_o, cmp_r_o and cmp_p_o are 0, and ld_fout_o is 0 when lds_i=0 and run_i=1 (the lock flag resets low).
- R2: With pol_i=1, when ref_i leads vco_i by k cycles, cp_up_o and cmp_r_o are 1 for k cycles starting at the edge that samples ref_i, while cp_dn_o and cmp_p_o stay 0. All four are 0 from the edge that samples vco_i onward.
- R3: With pol_i=1, when vco_i leads ref_i by k cycles, cp_dn_o and cmp_p_o are 1 for those k cycles and cp_up_o and cmp_r_o stay 0.
- R4: With pol_i=0 the drive-high and drive-low results of R2 and R3 are exchanged: a leading ref_i gives cp_dn_o/cmp_p_o, and a leading vco_i gives cp_up_o/cmp_r_o.
- R5: When ref_i and vco_i arrive in the same cycle, all four comparator outputs stay 0 (pump released). cp_up_o and cp_dn_o, and likewise cmp_r_o and cmp_p_o, are never 1 together.
- R6: With cp_en_i=0, cp_up_o and cp_dn_o are 0 in the same cycle whatever the phase. cmp_r_o and cmp_p_o still follow R2 to R4.
- R7: The error of a comparison is the cycle count from the leading pulse to the lagging pulse (0 for coincident pulses). A comparison with error of at most LOCK_W (4) counts as good.
- R8: With lds_i=1, ld_fout_o carries ref_i (pol_i=1) or vco_i (pol_i=0), registered once, so it is high in the cycle after the edge that samples the pulse.
- R9: The lock flag rises at the edge that closes the LOCK_CNT-th (3rd) consecutive good comparison, and stays high through further good comparisons, including an error of exactly 4.
- R10: The lock flag falls at the edge where an open comparison's count reaches UNLOCK_W (5), even before the lagging pulse. After that, LOCK_CNT new good comparisons are needed again.
- R11: Further pulses of the leading input are ignored while a comparison is open; the error still counts from the first one.
- R12: With run_i=0, ld_fout_o is 1 in the same cycle when lds_i=0. Pulses are ignored and the comparator outputs are 0. When run_i returns to 1 the lock flag is low and needs LOCK_CNT good comparisons.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock, timing base for error measurement |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 = normal operation, 0 = power save |
| ref_i | input | 1 | Divided reference pulse, one cycle wide |
| vco_i | input | 1 | Divided oscillator pulse, one cycle wide |
| pol_i | input | 1 | Comparator polarity, 1 = ref leading drives high |
| lds_i | input | 1 | Status pin select, 1 = monitor, 0 = lock flag |
| cp_en_i | input | 1 | 0 forces the pump command to release |
| cp_up_o | output | 1 | Pump drive-high command |
| cp_dn_o | output | 1 | Pump drive-low command; both 0 = high impedance |
| cmp_r_o | output | 1 | External comparator drive-high output |
| cmp_p_o | output | 1 | External comparator drive-low output |
| ld_fout_o | output | 1 | Lock flag or monitor pulse |

## Verification
The comparator outputs go active at the edge that samples the leading pulse and clear at the edge that samples the lagging one. Each comparator check is therefore due one edge after the leading pulse is driven and persists for exactly the error count. The lock flag moves at the edge that closes the qualifying comparison. An early unlock is due at the edge where the open count reaches 5. The monitor path adds one register. The enable, the status select and the power-save flag act within the same cycle. The driver books every expectation against the absolute edge number at which it is due. The monitor samples a quarter period after each rising edge and compares only items whose due edge has arrived.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    LEAD_NONE = 2'd0,
    LEAD_REF  = 2'd1,
    LEAD_VCO  = 2'd2
  } lead_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int UNLOCK_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ref_i,
  input  logic             vco_i,
  output lead_e            lead_o,
  output logic             done_o,
  output logic [CNT_W-1:0] err_o,
  output logic             over_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] Unlock = CNT_W'(UNLOCK_W);

  lead_e            lead_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_q <= LEAD_NONE;
      cnt_q  <= '0;
    end else if (!run_i) begin
      lead_q <= LEAD_NONE;
      cnt_q  <= '0;
    end else begin
      unique case (lead_q)
        LEAD_NONE: begin
          if (ref_i && !vco_i) begin
            lead_q <= LEAD_REF;
            cnt_q  <= CNT_W'(1);
          end else if (vco_i && !ref_i) begin
            lead_q <= LEAD_VCO;
            cnt_q  <= CNT_W'(1);
          end
        end
        LEAD_REF: begin
          if (vco_i) lead_q <= LEAD_NONE;
          else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
        end
        LEAD_VCO: begin
          if (ref_i) lead_q <= LEAD_NONE;
          else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
        end
        default: lead_q <= LEAD_NONE;
      endcase
    end
  end

  // comparison closes when the lagging pulse arrives, or both coincide
  always_comb begin
    done_o = 1'b0;
    if (run_i) begin
      unique case (lead_q)
        LEAD_NONE: done_o = ref_i && vco_i;
        LEAD_REF:  done_o = vco_i;
        LEAD_VCO:  done_o = ref_i;
        default:   done_o = 1'b0;
      endcase
    end
  end

  assign err_o  = (lead_q == LEAD_NONE) ? '0 : cnt_q;
  assign over_o = run_i && (lead_q != LEAD_NONE) && (cnt_q >= Unlock);
  assign lead_o = lead_q;
endmodule

// File: rtl/lock_filter.sv
module lock_filter #(
  parameter int CNT_W    = 8,
  parameter int LOCK_W   = 4,
  parameter int LOCK_CNT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] err_i,
  input  logic             over_i,
  output logic             lock_o
);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam logic [CNT_W-1:0] LockLim = CNT_W'(LOCK_W);
  localparam logic [GW-1:0]    GoodMax = GW'(LOCK_CNT);
  localparam logic [GW-1:0]    GoodArm = GW'(LOCK_CNT - 1);

  logic [GW-1:0] good_q;
  logic          lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (!run_i || over_i) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (done_i) begin
      if (err_i <= LockLim) begin
        if (good_q >= GoodArm) lock_q <= 1'b1;
        if (good_q != GoodMax) good_q <= good_q + 1'b1;
      end else begin
        // between the two windows: restart the run, keep the flag
        good_q <= '0;
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
  import pfd_pkg::*;
#(
  parameter bit MON_REG = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  pol_i,
  input  logic  lds_i,
  input  logic  cp_en_i,
  input  logic  ref_i,
  input  logic  vco_i,
  input  lead_e lead_i,
  input  logic  lock_i,
  output logic  cp_up_o,
  output logic  cp_dn_o,
  output logic  cmp_r_o,
  output logic  cmp_p_o,
  output logic  ld_fout_o
);
  logic ref_lead, vco_lead, up_cmd, dn_cmd, mon_src, mon;

  assign ref_lead = (lead_i == LEAD_REF);
  assign vco_lead = (lead_i == LEAD_VCO);
  assign up_cmd   = pol_i ? ref_lead : vco_lead;
  assign dn_cmd   = pol_i ? vco_lead : ref_lead;

  assign cmp_r_o  = up_cmd;
  assign cmp_p_o  = dn_cmd;
  assign cp_up_o  = up_cmd && cp_en_i;
  assign cp_dn_o  = dn_cmd && cp_en_i;

  assign mon_src  = pol_i ? ref_i : vco_i;

  generate
    if (MON_REG) begin : g_mon_reg
      logic mon_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mon_q <= 1'b0;
        else         mon_q <= mon_src;
      end
      assign mon = mon_q;
    end else begin : g_mon_comb
      assign mon = mon_src;
    end
  endgenerate

  assign ld_fout_o = lds_i ? mon : (lock_i || !run_i);
endmodule

// File: rtl/phase_lock_det.sv
module phase_lock_det
  import pfd_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LOCK_W   = 4,
  parameter int UNLOCK_W = 5,
  parameter int LOCK_CNT = 3,
  parameter bit MON_REG  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ref_i,
  input  logic vco_i,
  input  logic pol_i,
  input  logic lds_i,
  input  logic cp_en_i,
  output logic cp_up_o,
  output logic cp_dn_o,
  output logic cmp_r_o,
  output logic cmp_p_o,
  output logic ld_fout_o
);
  lead_e            lead;
  logic             done;
  logic [CNT_W-1:0] err;
  logic             over;
  logic             lock;

  pfd_core #(.CNT_W(CNT_W), .UNLOCK_W(UNLOCK_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_i),
    .ref_i (ref_i),
    .vco_i (vco_i),
    .lead_o(lead),
    .done_o(done),
    .err_o (err),
    .over_o(over)
  );

  lock_filter #(.CNT_W(CNT_W), .LOCK_W(LOCK_W), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_i),
    .done_i(done),
    .err_i (err),
    .over_i(over),
    .lock_o(lock)
  );

  pfd_out_stage #(.MON_REG(MON_REG)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .pol_i    (pol_i),
    .lds_i    (lds_i),
    .cp_en_i  (cp_en_i),
    .ref_i    (ref_i),
    .vco_i    (vco_i),
    .lead_i   (lead),
    .lock_i   (lock),
    .cp_up_o  (cp_up_o),
    .cp_dn_o  (cp_dn_o),
    .cmp_r_o  (cmp_r_o),
    .cmp_p_o  (cmp_p_o),
    .ld_fout_o(ld_fout_o)
  );
endmodule

// File: rtl/phase_lock_det_chk.sv
module phase_lock_det_chk
  import pfd_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int LOCK_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             ref_i,
  input logic             vco_i,
  input logic             pol_i,
  input logic             lds_i,
  input logic             cp_en_i,
  input logic             cp_up_o,
  input logic             cp_dn_o,
  input logic             cmp_r_o,
  input logic             cmp_p_o,
  input logic             ld_fout_o,
  input lead_e            lead,
  input logic             done,
  input logic [CNT_W-1:0] err,
  input logic             over,
  input logic             lock
);
  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmp_r_o && cmp_p_o) && !(cp_up_o && cp_dn_o));

  a_r6_forced_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cp_en_i |-> (!cp_up_o && !cp_dn_o));

  a_r6_pump_implies_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_up_o |-> cmp_r_o) and (cp_dn_o |-> cmp_p_o));

  // R2 / R4: a lone ref pulse from idle opens the polarity-matched command
  a_r4_ref_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && lead == LEAD_NONE && ref_i && !vco_i)
      |=> ((pol_i != $past(pol_i)) || (pol_i ? cmp_r_o : cmp_p_o)));

  a_r10_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over |=> !lock);

  a_r9_lock_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock) |-> $past(done && (err <= CNT_W'(LOCK_W))));

  a_r12_ps_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !lds_i) |-> ld_fout_o);

  a_r12_ps_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (lead == LEAD_NONE && !lock));
endmodule

bind phase_lock_det phase_lock_det_chk #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_i),
  .ref_i    (ref_i),
  .vco_i    (vco_i),
  .pol_i    (pol_i),
  .lds_i    (lds_i),
  .cp_en_i  (cp_en_i),
  .cp_up_o  (cp_up_o),
  .cp_dn_o  (cp_dn_o),
  .cmp_r_o  (cmp_r_o),
  .cmp_p_o  (cmp_p_o),
  .ld_fout_o(ld_fout_o),
  .lead     (lead),
  .done     (done),
  .err      (err),
  .over     (over),
  .lock     (lock)
);

// File: tb/phase_lock_det_tb_top.sv
module phase_lock_det_tb_top;
  localparam int CLK_P = 10;
  localparam int UNL   = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic run = 1'b1, ref_p = 1'b0, vco_p = 1'b0;
  logic pol = 1'b1, lds = 1'b0, cp_en = 1'b1;
  logic cp_up, cp_dn, cmp_r, cmp_p, ld_fout;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    int         due;
    logic [4:0] mask;
    logic [4:0] val;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc++;

  phase_lock_det dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .ref_i(ref_p), .vco_i(vco_p),
    .pol_i(pol), .lds_i(lds), .cp_en_i(cp_en),
    .cp_up_o(cp_up), .cp_dn_o(cp_dn), .cmp_r_o(cmp_r), .cmp_p_o(cmp_p),
    .ld_fout_o(ld_fout)
  );

  task automatic push(int due, logic [4:0] mask, logic [4:0] val, string req);
    exp_t e;
    e.due = due; e.mask = mask; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: {cp_up, cp_dn, cmp_r, cmp_p, ld_fout}
  always @(posedge clk) begin
    #(CLK_P/4);
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      logic [4:0] obs;
      e = exp_q.pop_front();
      obs = {cp_up, cp_dn, cmp_r, cmp_p, ld_fout};
      n_chk++;
      if (e.due < cyc || (obs & e.mask) != e.val) begin
        n_fail++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                 e.req, cyc, obs & e.mask, e.val, e.mask);
      end
    end
  end

  // one comparison: leading pulse, lagging pulse k cycles later
  task automatic pair(bit fr_first, int k, bit dup, int ld_pre, int ld_post, string req);
    int s;
    logic hi;
    hi = (fr_first == pol);
    @(negedge clk);
    s = cyc + 1;
    for (int j = 0; j <= k + 1; j++) begin
      logic lead_d, lag_d, fr_d, fp_d;
      logic [4:0] m, v;
      if (j > 0) @(negedge clk);
      lead_d = (j == 0) || (dup && j == 2 && k > 2);
      lag_d  = (j == k);
      fr_d   = fr_first ? lead_d : lag_d;
      fp_d   = fr_first ? lag_d : lead_d;
      ref_p  = fr_d;
      vco_p  = fp_d;
      m = 5'b11110;
      v = 5'b0;
      if (j < k) v[4:1] = {hi & cp_en, !hi & cp_en, hi, !hi};
      if (lds) begin
        m[0] = 1'b1; v[0] = pol ? fr_d : fp_d;
      end else if (j >= k && ld_post >= 0) begin
        m[0] = 1'b1; v[0] = ld_post[0];
      end else if (j < k && ld_pre >= 0) begin
        m[0] = 1'b1; v[0] = (j >= UNL) ? 1'b0 : ld_pre[0];
      end
      push(s + j, m, v, req);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog cyc=%0d actual=running expected=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    push(cyc + 1, 5'b11111, 5'b00000, "R1 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    push(cyc + 1, 5'b11111, 5'b00000, "R1 after reset");
    repeat (2) @(negedge clk);

    pair(1'b1, 3, 1'b0, 0, 0, "R2 ref leads, R7 good 1");
    pair(1'b0, 2, 1'b0, 0, 0, "R3 vco leads, R7 good 2");
    pair(1'b1, 0, 1'b0, 0, 1, "R5 coincident, R9 third good locks");

    pol = 1'b0;
    pair(1'b1, 4, 1'b0, 1, 1, "R4 swapped, R9 error 4 keeps lock");
    pair(1'b0, 7, 1'b0, 1, 0, "R4 swapped, R10 early unlock");

    pol = 1'b1;
    pair(1'b1, 1, 1'b0, 0, 0, "R10 relock good 1");
    pair(1'b0, 2, 1'b0, 0, 0, "R10 relock good 2");
    pair(1'b1, 3, 1'b0, 0, 1, "R9 relock good 3");
    pair(1'b1, 5, 1'b0, 1, 0, "R10 error 5 unlocks");

    cp_en = 1'b0;
    pair(1'b1, 3, 1'b0, 0, 0, "R6 pump released, cmp active");
    cp_en = 1'b1;
    pair(1'b1, 4, 1'b1, 0, 0, "R11 repeated lead pulse ignored");

    lds = 1'b1;
    pair(1'b1, 2, 1'b0, -1, -1, "R8 monitor ref");
    pol = 1'b0;
    pair(1'b1, 2, 1'b0, -1, -1, "R8 monitor vco");
    @(negedge clk);
    lds = 1'b0;
    push(cyc + 1, 5'b00001, 5'b00001, "R9 lock held after monitor");

    @(negedge clk);
    run = 1'b0;
    push(cyc + 1, 5'b11111, 5'b00001, "R12 flag forced high");
    @(negedge clk);
    ref_p = 1'b1;
    push(cyc + 1, 5'b11111, 5'b00001, "R12 pulse ignored");
    @(negedge clk);
    ref_p = 1'b0;
    push(cyc + 1, 5'b11111, 5'b00001, "R12 idle");
    @(negedge clk);
    run = 1'b1;
    push(cyc + 1, 5'b00001, 5'b00000, "R12 history cleared");
    pair(1'b1, 1, 1'b0, 0, 0, "R12 wake good 1");
    pair(1'b0, 1, 1'b0, 0, 0, "R12 wake good 2");
    pair(1'b1, 1, 1'b0, 0, 1, "R12 wake good 3");

    repeat (4) @(negedge clk);
    if (exp_q.size() > 0) begin
      n_chk += exp_q.size();
      n_fail += exp_q.size();
      $display("FAIL pending cyc=%0d actual=%0d expected=0", cyc, exp_q.size());
    end
    summary();
    $finish;
  end
endmodule